// File: doc/BRIEF.md
# DRAM Range Node Decoder

This block takes a physical system address and finds out which memory node owns it. It does this by comparing the address with a small table of programmable DRAM address ranges, one range per node. Each range is described by four register words: a base word, a base-high byte, a limit word and a limit-high byte. The base and limit words also carry an enable, a destination node number and a node-interleave enable/select pair. When node interleaving is on, several ranges cover the same address span, and low page-address bits choose between them.

The decoder is one pipeline stage. The address and the table are sampled on a rising clock edge, and the result appears on the outputs after that edge. The result holds a hit flag, an out-of-bounds flag, the node number, the base address of the winning range, and the number of address bits that node interleaving uses in that range. A later stage uses the base address and the interleave bit count to normalize the address.

Top module: `node_range_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are cleared to zero on that edge. This holds even when the inputs would produce a hit.
- R2: The outputs change only on a rising clock edge. They reflect the address and table words present at the previous rising edge (one cycle of latency).
- R3: A range takes part in decoding only when at least one of bits 1:0 of its base word is set. Both the pattern 01 and the pattern 10 enable the range.
- R4: The base address of a range is {base-high byte, base word bits 31:16, 24 zero bits}. This base is reported on `base_addr_o` for the winning range.
- R5: The limit of a range is {limit-high byte, limit word bits 31:16, 24 one bits}, and it is inclusive. Limit word bits 15:11 have no effect on the limit.
- R6: A range matches when base <= address <= limit and one of two conditions holds: its interleave enable (base word bits 10:8) is zero, or its interleave select (limit word bits 10:8) equals address bits 14:12 ANDed with the interleave enable.
- R7: The reported node number is bits 2:0 of the winning range's limit word.
- R8: When several ranges match, the lowest-numbered range wins and all higher ranges are ignored.
- R9: The interleave bit count on `ilv_bits_o` depends on the interleave enable: 0, 1, 3 and 7 give 0, 1, 2 and 3. Every other enable value gives 0.
- R10: When no range matches, `oob_o` is 1 and `hit_o` is 0, and the node, base and bit-count outputs are all zero. When a range matches, `hit_o` is 1 and `oob_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 48 | Physical system address to decode |
| base_lo_i | input | 32*NUM_RANGES | Packed base words, range k at bits [32k+31:32k] |
| base_hi_i | input | 8*NUM_RANGES | Packed base-high bytes (address bits 47:40) |
| lim_lo_i | input | 32*NUM_RANGES | Packed limit words |
| lim_hi_i | input | 8*NUM_RANGES | Packed limit-high bytes (address bits 47:40) |
| hit_o | output | 1 | A range matched |
| oob_o | output | 1 | No range matched |
| node_o | output | 3 | Node number of the winning range |
| base_addr_o | output | 48 | Base address of the winning range |
| ilv_bits_o | output | 2 | Node-interleave bit count of the winning range |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edges have passed. They also assume that the address and table inputs are stable across each rising edge. The bench meets both conditions: it drives every input on the falling edge and keeps reset high for several cycles at the start.

The assertions do not assume that ranges are disjoint or that every range's limit is at least its base. The stimulus therefore programs overlapping, disabled and inverted ranges on purpose, as well as every interleave enable value. Random addresses are mostly chosen inside a programmed span, so that hits, interleave rejections and misses all occur often.

// File: rtl/node_dec_pkg.sv
package node_dec_pkg;

  localparam int ADDR_W   = 48;
  localparam int NODE_W   = 3;
  localparam int ILV_W    = 3;
  localparam int BITS_W   = 2;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int PAD_W    = 24;

  typedef struct packed {
    logic              match;
    logic [NODE_W-1:0] node;
    logic [ADDR_W-1:0] base;
    logic [BITS_W-1:0] ilv_bits;
  } range_res_t;

  // Interleave enable mask to number of consumed address bits.
  function automatic logic [BITS_W-1:0] ilv_count(input logic [ILV_W-1:0] en);
    logic [BITS_W-1:0] n;
    case (en)
      3'b001:  n = 2'd1;
      3'b011:  n = 2'd2;
      3'b111:  n = 2'd3;
      default: n = 2'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ndec_range_entry.sv
module ndec_range_entry
  import node_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] base_lo_i,
  input  logic [BYTE_W-1:0] base_hi_i,
  input  logic [WORD_W-1:0] lim_lo_i,
  input  logic [BYTE_W-1:0] lim_hi_i,
  output range_res_t        res_o
);

  logic              enabled;
  logic [ILV_W-1:0]  ilv_en;
  logic [ILV_W-1:0]  ilv_sel;
  logic [ADDR_W-1:0] lo_bound;
  logic [ADDR_W-1:0] hi_bound;
  logic              in_span;
  logic              ilv_ok;

  always_comb begin
    enabled  = |base_lo_i[1:0];
    ilv_en   = base_lo_i[10:8];
    ilv_sel  = lim_lo_i[10:8];
    lo_bound = {base_hi_i, base_lo_i[31:16], {PAD_W{1'b0}}};
    hi_bound = {lim_hi_i, lim_lo_i[31:16], {PAD_W{1'b1}}};
    in_span  = (addr_i >= lo_bound) && (addr_i <= hi_bound);
    ilv_ok   = (ilv_en == '0) || (ilv_sel == (addr_i[14:12] & ilv_en));

    res_o.match    = enabled & in_span & ilv_ok;
    res_o.node     = lim_lo_i[NODE_W-1:0];
    res_o.base     = lo_bound;
    res_o.ilv_bits = ilv_count(ilv_en);
  end

endmodule

// File: rtl/ndec_first_pick.sv
module ndec_first_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  generate
    for (genvar k = 0; k < N; k++) begin : g_chain
      assign grant_o[k]  = req_i[k] & ~seen[k];
      assign seen[k+1]   = seen[k] | req_i[k];
    end
  endgenerate

  assign any_o = seen[N];

endmodule

// File: rtl/ndec_result_mux.sv
module ndec_result_mux
  import node_dec_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]         grant_i,
  input  range_res_t [N-1:0]   res_i,
  output range_res_t           res_o
);

  localparam int RES_W = $bits(range_res_t);

  logic [RES_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < N; k++) begin
      acc = acc | ({RES_W{grant_i[k]}} & res_i[k]);
    end
    res_o = range_res_t'(acc);
  end

endmodule

// File: rtl/node_range_decoder.sv
module node_range_decoder
  import node_dec_pkg::*;
#(
  parameter int NUM_RANGES = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W*NUM_RANGES-1:0] base_lo_i,
  input  logic [BYTE_W*NUM_RANGES-1:0] base_hi_i,
  input  logic [WORD_W*NUM_RANGES-1:0] lim_lo_i,
  input  logic [BYTE_W*NUM_RANGES-1:0] lim_hi_i,
  output logic                         hit_o,
  output logic                         oob_o,
  output logic [NODE_W-1:0]            node_o,
  output logic [ADDR_W-1:0]            base_addr_o,
  output logic [BITS_W-1:0]            ilv_bits_o
);

  range_res_t [NUM_RANGES-1:0] per_range;
  logic       [NUM_RANGES-1:0] match_vec;
  logic       [NUM_RANGES-1:0] grant_vec;
  logic                        any_match;
  range_res_t                  chosen;

  generate
    for (genvar k = 0; k < NUM_RANGES; k++) begin : g_range
      ndec_range_entry u_entry (
        .addr_i    (addr_i),
        .base_lo_i (base_lo_i[k*WORD_W +: WORD_W]),
        .base_hi_i (base_hi_i[k*BYTE_W +: BYTE_W]),
        .lim_lo_i  (lim_lo_i[k*WORD_W +: WORD_W]),
        .lim_hi_i  (lim_hi_i[k*BYTE_W +: BYTE_W]),
        .res_o     (per_range[k])
      );
      assign match_vec[k] = per_range[k].match;
    end
  endgenerate

  ndec_first_pick #(.N(NUM_RANGES)) u_pick (
    .req_i   (match_vec),
    .grant_o (grant_vec),
    .any_o   (any_match)
  );

  ndec_result_mux #(.N(NUM_RANGES)) u_mux (
    .grant_i (grant_vec),
    .res_i   (per_range),
    .res_o   (chosen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o       <= 1'b0;
      oob_o       <= 1'b0;
      node_o      <= '0;
      base_addr_o <= '0;
      ilv_bits_o  <= '0;
    end else begin
      hit_o       <= any_match;
      oob_o       <= ~any_match;
      node_o      <= chosen.node;
      base_addr_o <= chosen.base;
      ilv_bits_o  <= chosen.ilv_bits;
    end
  end

  // R8: at most one range is granted
  a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec));

  // R8: the granted range is always one that matched
  a_r8_grant_subset: assert property (@(posedge clk) disable iff (rst)
    (grant_vec & ~match_vec) == '0);

  // R10: a miss leaves every result field at zero
  a_r10_oob_zero_fields: assert property (@(posedge clk) disable iff (rst)
    oob_o |-> (node_o == '0 && base_addr_o == '0 && ilv_bits_o == '0));

  // R10: after a decode cycle exactly one of hit/oob is set
  a_r10_hit_xor_oob: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hit_o != oob_o));

  // R2: a hit comes from a match present one edge earlier
  a_r2_hit_from_match: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(|match_vec));

  // R4: reported base never lies above the address that hit
  a_r4_base_not_above: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> base_addr_o <= $past(addr_i));

  // R4: reported base has its low 24 bits clear
  a_r4_base_low_clear: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> base_addr_o[PAD_W-1:0] == '0);

endmodule

// File: tb/test_node_range_decoder.sv
`timescale 1ns/1ps
module test_node_range_decoder;

  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [47:0]   addr_i = '0;
  logic [32*NR-1:0] base_lo_i = '0;
  logic [8*NR-1:0]  base_hi_i = '0;
  logic [32*NR-1:0] lim_lo_i = '0;
  logic [8*NR-1:0]  lim_hi_i = '0;
  logic          hit_o, oob_o;
  logic [2:0]    node_o;
  logic [47:0]   base_addr_o;
  logic [1:0]    ilv_bits_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  node_range_decoder #(.NUM_RANGES(NR)) i_node_range_decoder (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .base_lo_i(base_lo_i), .base_hi_i(base_hi_i),
    .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i),
    .hit_o(hit_o), .oob_o(oob_o), .node_o(node_o),
    .base_addr_o(base_addr_o), .ilv_bits_o(ilv_bits_o)
  );

  // expected results of the last applied inputs
  bit              e_hit;
  int              e_node;
  longint unsigned e_base;
  int              e_bits;

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  task automatic model();
    e_hit = 0; e_node = 0; e_base = 0; e_bits = 0;
    for (int k = 0; k < NR; k++) begin
      longint unsigned bl, bh, ll, lh, b, l, a;
      int en, sel;
      bl = longint'(base_lo_i[k*32 +: 32]);
      bh = longint'(base_hi_i[k*8 +: 8]);
      ll = longint'(lim_lo_i[k*32 +: 32]);
      lh = longint'(lim_hi_i[k*8 +: 8]);
      a  = longint'(addr_i);
      b  = (bh << 40) + (((bl >> 16) % 65536) << 24);
      l  = (lh << 40) + (((ll >> 16) % 65536) << 24) + 64'hFFFFFF;
      en  = int'((bl >> 8) % 8);
      sel = int'((ll >> 8) % 8);
      if (!e_hit && (bl % 4) != 0 && a >= b && a <= l &&
          (en == 0 || sel == (int'((a >> 12) % 8) & en))) begin
        e_hit  = 1;
        e_node = int'(ll % 8);
        e_base = b;
        if (en == 1) e_bits = 1;
        else if (en == 3) e_bits = 2;
        else if (en == 7) e_bits = 3;
        else e_bits = 0;
      end
    end
  endtask

  // inputs are set at a falling edge; result checked at the next falling edge
  task automatic step();
    model();
    @(negedge clk);
    chk("R6/R10 hit", longint'(hit_o), longint'(e_hit));
    chk("R10 oob", longint'(oob_o), longint'(!e_hit));
    chk("R7 node", longint'(node_o), longint'(e_node));
    chk("R4 base", longint'(base_addr_o), e_base);
    chk("R9 bits", longint'(ilv_bits_o), longint'(e_bits));
  endtask

  task automatic set_rng(input int k, input int en2, input int b16, input int bhi,
                         input int l16, input int lhi, input int node,
                         input int ien, input int isel);
    base_lo_i[k*32 +: 32] = {b16[15:0], 5'b0, ien[2:0], 6'b0, en2[1:0]};
    base_hi_i[k*8 +: 8]   = bhi[7:0];
    lim_lo_i[k*32 +: 32]  = {l16[15:0], 5'h1F, isel[2:0], 5'b0, node[2:0]};
    lim_hi_i[k*8 +: 8]    = lhi[7:0];
  endtask

  task automatic plain_table();
    for (int k = 0; k < NR; k++)
      set_rng(k, 1, k*16, 0, k*16+15, 0, 7-k, 0, 0);
  endtask

  initial begin
    plain_table();
    addr_i = 48'h3000_0000;
    // R1: reset dominates even when inputs would hit
    repeat (3) @(negedge clk);
    chk("R1 hit", longint'(hit_o), 0);
    chk("R1 oob", longint'(oob_o), 0);
    chk("R1 node", longint'(node_o), 0);
    chk("R1 base", longint'(base_addr_o), 0);
    rst = 1'b0;

    // R4/R7 basic hit in range 3
    addr_i = 48'h3000_0000; step();
    chk("R7 node range3", longint'(node_o), 4);

    // R2: changing inputs between edges leaves outputs unchanged
    addr_i = 48'hF000_0000;
    #2;
    chk("R2 hold", longint'(hit_o), 1);
    step();

    // R5: inclusive limit with low ones; limit word bits 15:11 set but ignored
    addr_i = 48'h3FFF_FFFF; step();
    chk("R5 at limit", longint'(node_o), 4);
    addr_i = 48'h8000_0000; step();
    chk("R5 past top limit", longint'(oob_o), 1);

    // R3: enable bits
    set_rng(2, 0, 32, 0, 47, 0, 5, 0, 0);
    addr_i = 48'h2000_0000; step();
    chk("R3 disabled", longint'(oob_o), 1);
    set_rng(2, 2, 32, 0, 47, 0, 5, 0, 0);
    step();
    chk("R3 enable 10", longint'(node_o), 5);

    // R8: overlapping ranges, lowest wins
    set_rng(5, 3, 16, 0, 31, 0, 2, 0, 0);
    addr_i = 48'h1800_0000; step();
    chk("R8 lowest", longint'(node_o), 6);
    set_rng(1, 0, 16, 0, 31, 0, 6, 0, 0);
    step();
    chk("R8 next", longint'(node_o), 2);
    plain_table();

    // R6: interleave select on address bit 12
    set_rng(0, 1, 0, 0, 15, 0, 3, 1, 1);
    addr_i = 48'h0000_1000; step();
    chk("R6 sel match", longint'(node_o), 3);
    addr_i = 48'h0000_0000; step();
    chk("R6 sel reject", longint'(oob_o), 1);

    // R9: every interleave enable value, select 0, address 0 matches
    for (int v = 0; v < 8; v++) begin
      set_rng(0, 1, 0, 0, 15, 0, 3, v, 0);
      addr_i = 48'h0; step();
      chk("R9 count", longint'(ilv_bits_o), (v == 1) ? 1 : (v == 3) ? 2 : (v == 7) ? 3 : 0);
    end

    // high-byte use for base and limit (R4, R5)
    set_rng(6, 1, 16'hFF00, 8'h12, 16'hFF0F, 8'h12, 1, 0, 0);
    addr_i = 48'h12FF_0500_0000; step();
    chk("R4 high base", longint'(base_addr_o), 64'h12FF_0000_0000);

    // random phase compared every cycle
    for (int t = 0; t < 3000; t++) begin
      if (t % 40 == 0) begin
        for (int k = 0; k < NR; k++) begin
          int b16, l16;
          b16 = int'($urandom % 64);
          l16 = b16 + int'($urandom % 12) - 2;
          if (l16 < 0) l16 = 0;
          set_rng(k, int'($urandom % 4), b16, int'($urandom % 2), l16,
                  int'($urandom % 2), int'($urandom % 8),
                  int'($urandom % 8), int'($urandom % 8));
        end
      end
      begin
        longint unsigned a;
        a = (longint'($urandom % 2) << 40) + (longint'($urandom % 72) << 24)
          + longint'($urandom % 32'h0100_0000);
        addr_i = a[47:0];
      end
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule